// File: doc/BRIEF.md
# Batched Integer Dot-Product Accumulator

This block forms eight integer dot products in a single operation. A single shared operand stream A is paired with eight separate operand streams B0..B7. Each lane multiplies A by its own B element and adds the product into its own accumulator. The accumulator is four times as wide as an element, and every lane begins from a caller-supplied starting value. One element index is delivered per clock: on each cycle the caller drives A[k] and all eight B lanes' element k together. Index k runs upward from 0 to vl-1.

An operation begins with a one-cycle `start` request, which also carries the configuration:
- the B register specifier,
- the element size,
- the signedness of each operand,
- a lane mask,
- the element count,
- a resume index.

The block derives two values from the specifier: the group base register and the destination element offset of the eight results. It checks that the request is legal. When the operation ends, it raises a one-cycle `done` with all eight results in parallel. An illegal request raises a one-cycle `err` and changes no output.

Top module: `batch_dot_acc`

## Requirements
- R1: On an accepted start, `grpBase` becomes `bReg` with its low three bits cleared, and `accIdx` becomes `bReg[2:0]` times 8. Both hold until the next accepted start.
- R2: Each unmasked lane i ends with `accIn` lane i plus the sum over k = 0..vl-1 of A[k]*Bi[k]. Element k is driven in the (k+1)-th cycle after the start cycle. Lane i of `bElems` is bits [16i+15:16i], and lane i of `accIn` and `accOut` is bits [64i+63:64i].
- R3: With `elemWide` = 0 (8-bit mode), only bits [7:0] of each element are used. Accumulation is modulo 2^32, only the low 32 bits of `accIn` are taken, and bits [63:32] of each result lane are zero.
- R4: With `elemWide` = 1 (16-bit mode), all 16 element bits are used and accumulation is modulo 2^64.
- R5: B is sign-extended when `bSigned` = 1 and zero-extended when it is 0. A is sign-extended when `aSigned` = 1 and zero-extended when it is 0.
- R6: A lane whose `laneMask` bit is 0 returns its starting value unchanged.
- R7: A start with `startIdx` not equal to 0 is illegal. It is answered in the next cycle by `err` = 1 with `done` = 0, and `accOut` is unchanged.
- R8: A start is also illegal, with the same response as R7, when `bReg[2:0]`*8 times the accumulator width (32 or 64) is not below parameter VLEN (default 1024).
- R9: `done` is high for exactly one cycle, the cycle after the last element is consumed, and it is low while elements are being consumed.
- R10: With vl = 0, `done` rises in the cycle after start and every lane returns its starting value (truncated to 32 bits in 8-bit mode).
- R11: A `start` while `busy` is high is ignored. The running operation's configuration and results are unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Operation request, sampled when idle |
| bReg | input | 5 | B register specifier |
| elemWide | input | 1 | 0: 8-bit elements, 1: 16-bit elements |
| aSigned | input | 1 | A operand signed when 1 |
| bSigned | input | 1 | B operands signed when 1 |
| laneMask | input | 8 | Per-lane enable |
| vl | input | 8 | Element count |
| startIdx | input | 8 | Resume index, must be zero |
| accIn | input | 512 | Eight starting accumulator values |
| aElem | input | 16 | Shared A element for the current index |
| bElems | input | 128 | Eight B elements for the current index |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | One-cycle illegal-request pulse |
| grpBase | output | 5 | B register group base |
| accIdx | output | 6 | Destination element offset |
| accOut | output | 512 | Eight accumulator results |

## Verification
A wrong internal state shows up at the result ports no later than the `done` cycle. Three cases are covered:
- A wrong lane extension, width or mask latch shows as a wrong lane value.
- A misplaced count shows as `done` arriving early or late against the expected cycle.
- A lost configuration latch shows when a start held high during a run changes `grpBase` or a result.

Illegal requests are checked in the very next cycle. `err` must be high there, and `accOut` must equal the value it had before the request.

// File: rtl/batch_dot_pkg.sv
`timescale 1ns/1ps
package batch_dot_pkg;
  typedef struct packed {
    logic ld;
    logic step;
  } strobe_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIN  = 2'd2
  } state_t;
endpackage

// File: rtl/batch_dot_ctrl.sv
`timescale 1ns/1ps
module batch_dot_ctrl
  import batch_dot_pkg::*;
#(
  parameter int VL_W  = 8,
  parameter int LANES = 8,
  parameter int ACC_W = 64,
  parameter int VLEN  = 1024,
  localparam int LOW_W = $clog2(LANES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [VL_W-1:0]  vl,
  input  logic [VL_W-1:0]  startIdx,
  input  logic [LOW_W-1:0] bLow,
  input  logic             elemWide,
  output strobe_t          strb,
  output logic             busy,
  output logic             done,
  output logic             err
);
  state_t state;
  logic [VL_W-1:0] cnt;
  logic [VL_W-1:0] vlQ;
  logic legal;
  int offBits;

  always_comb begin
    offBits = int'(bLow) * LANES * (elemWide ? ACC_W : ACC_W / 2);
    legal   = (startIdx == '0) && (offBits < VLEN);
  end

  always_comb begin
    strb.ld   = (state == ST_IDLE) && start && legal;
    strb.step = (state == ST_RUN);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      cnt   <= '0;
      vlQ   <= '0;
      err   <= 1'b0;
    end else begin
      err <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (start) begin
            if (legal) begin
              vlQ   <= vl;
              cnt   <= '0;
              state <= (vl == '0) ? ST_FIN : ST_RUN;
            end else begin
              err <= 1'b1;
            end
          end
        end
        ST_RUN: begin
          cnt <= cnt + VL_W'(1);
          if (cnt + VL_W'(1) == vlQ) state <= ST_FIN;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign busy = (state != ST_IDLE);
  assign done = (state == ST_FIN);
endmodule

// File: rtl/batch_dot_dp.sv
`timescale 1ns/1ps
module batch_dot_dp
  import batch_dot_pkg::*;
#(
  parameter int LANES  = 8,
  parameter int ELEM_W = 16,
  parameter int SPEC_W = 5,
  localparam int ACC_W = 4 * ELEM_W,
  localparam int LOW_W = $clog2(LANES),
  localparam int IDX_W = 2 * LOW_W
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  strobe_t                 strb,
  input  logic [SPEC_W-1:0]       bReg,
  input  logic                    elemWide,
  input  logic                    aSigned,
  input  logic                    bSigned,
  input  logic [LANES-1:0]        laneMask,
  input  logic [LANES*ACC_W-1:0]  accIn,
  input  logic [ELEM_W-1:0]       aElem,
  input  logic [LANES*ELEM_W-1:0] bElems,
  output logic [SPEC_W-1:0]       grpBase,
  output logic [IDX_W-1:0]        accIdx,
  output logic [LANES*ACC_W-1:0]  accOut
);
  localparam int EXT_W  = ELEM_W + 1;
  localparam int PROD_W = 2 * EXT_W;
  localparam int HALF_E = ELEM_W / 2;
  localparam int HALF_A = ACC_W / 2;

  logic wideQ, aSgnQ, bSgnQ;
  logic [LANES-1:0] maskQ;
  logic signed [EXT_W-1:0] aExt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wideQ   <= 1'b0;
      aSgnQ   <= 1'b0;
      bSgnQ   <= 1'b0;
      maskQ   <= '0;
      grpBase <= '0;
      accIdx  <= '0;
    end else if (strb.ld) begin
      wideQ   <= elemWide;
      aSgnQ   <= aSigned;
      bSgnQ   <= bSigned;
      maskQ   <= laneMask;
      grpBase <= {bReg[SPEC_W-1:LOW_W], LOW_W'(0)};
      accIdx  <= {bReg[LOW_W-1:0], LOW_W'(0)};
    end
  end

  always_comb begin
    if (wideQ) aExt = {aSgnQ & aElem[ELEM_W-1], aElem};
    else       aExt = {{(EXT_W-HALF_E){aSgnQ & aElem[HALF_E-1]}}, aElem[HALF_E-1:0]};
  end

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic [ELEM_W-1:0] bLane;
    logic signed [EXT_W-1:0] bExt;
    logic signed [PROD_W-1:0] prod;
    logic [ACC_W-1:0] prodWide;
    logic [ACC_W-1:0] accQ;
    logic [ACC_W-1:0] accInit;

    assign bLane   = bElems[i*ELEM_W +: ELEM_W];
    assign accInit = accIn[i*ACC_W +: ACC_W];

    always_comb begin
      if (wideQ) bExt = {bSgnQ & bLane[ELEM_W-1], bLane};
      else       bExt = {{(EXT_W-HALF_E){bSgnQ & bLane[HALF_E-1]}}, bLane[HALF_E-1:0]};
      prod     = aExt * bExt;
      prodWide = {{(ACC_W-PROD_W){prod[PROD_W-1]}}, prod};
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        accQ <= '0;
      end else if (strb.ld) begin
        accQ <= elemWide ? accInit : {HALF_A'(0), accInit[HALF_A-1:0]};
      end else if (strb.step && maskQ[i]) begin
        if (wideQ) accQ <= accQ + prodWide;
        else       accQ <= {HALF_A'(0), accQ[HALF_A-1:0] + prodWide[HALF_A-1:0]};
      end
    end

    assign accOut[i*ACC_W +: ACC_W] = accQ;
  end
endmodule

// File: rtl/batch_dot_acc.sv
`timescale 1ns/1ps
module batch_dot_acc
  import batch_dot_pkg::*;
#(
  parameter int LANES  = 8,
  parameter int ELEM_W = 16,
  parameter int SPEC_W = 5,
  parameter int VL_W   = 8,
  parameter int VLEN   = 1024,
  localparam int ACC_W = 4 * ELEM_W,
  localparam int LOW_W = $clog2(LANES),
  localparam int IDX_W = 2 * LOW_W
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start,
  input  logic [SPEC_W-1:0]       bReg,
  input  logic                    elemWide,
  input  logic                    aSigned,
  input  logic                    bSigned,
  input  logic [LANES-1:0]        laneMask,
  input  logic [VL_W-1:0]         vl,
  input  logic [VL_W-1:0]         startIdx,
  input  logic [LANES*ACC_W-1:0]  accIn,
  input  logic [ELEM_W-1:0]       aElem,
  input  logic [LANES*ELEM_W-1:0] bElems,
  output logic                    busy,
  output logic                    done,
  output logic                    err,
  output logic [SPEC_W-1:0]       grpBase,
  output logic [IDX_W-1:0]        accIdx,
  output logic [LANES*ACC_W-1:0]  accOut
);
  strobe_t strb;

  batch_dot_ctrl #(
    .VL_W(VL_W), .LANES(LANES), .ACC_W(ACC_W), .VLEN(VLEN)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .vl(vl), .startIdx(startIdx),
    .bLow(bReg[LOW_W-1:0]), .elemWide(elemWide), .strb(strb),
    .busy(busy), .done(done), .err(err)
  );

  batch_dot_dp #(
    .LANES(LANES), .ELEM_W(ELEM_W), .SPEC_W(SPEC_W)
  ) u_dp (
    .clk(clk), .rst_n(rst_n), .strb(strb), .bReg(bReg), .elemWide(elemWide),
    .aSigned(aSigned), .bSigned(bSigned), .laneMask(laneMask), .accIn(accIn),
    .aElem(aElem), .bElems(bElems), .grpBase(grpBase), .accIdx(accIdx),
    .accOut(accOut)
  );
endmodule

// File: rtl/batch_dot_chk.sv
`timescale 1ns/1ps
module batch_dot_chk #(
  parameter int VL_W   = 8,
  parameter int SPEC_W = 5,
  parameter int IDX_W  = 6,
  parameter int OUT_W  = 512
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic [VL_W-1:0]   vl,
  input logic              busy,
  input logic              done,
  input logic              err,
  input logic [SPEC_W-1:0] grpBase,
  input logic [IDX_W-1:0]  accIdx,
  input logic [OUT_W-1:0]  accOut
);
  // R9: completion is a single-cycle pulse
  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R7: an illegal request leaves results untouched and does not complete
  p_err_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> ($stable(accOut) && !done));

  // R8: an illegal request never starts a run
  p_err_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> !busy);

  // R10: a zero-length request finishes (or is rejected) in the next cycle
  p_vl_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && vl == '0) |=> (done || err));

  // R11: configuration outputs hold while a run is in flight
  p_cfg_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> ($stable(grpBase) && $stable(accIdx)));

  // R9: leaving the busy state always passes through the done cycle
  p_done_exit_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(done));
endmodule

bind batch_dot_acc batch_dot_chk #(
  .VL_W(VL_W), .SPEC_W(SPEC_W), .IDX_W(IDX_W), .OUT_W(LANES*ACC_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .vl(vl), .busy(busy), .done(done),
  .err(err), .grpBase(grpBase), .accIdx(accIdx), .accOut(accOut)
);

// File: tb/test_batch_dot_acc.sv
`timescale 1ns/1ps
module test_batch_dot_acc;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [4:0] bReg = '0;
  logic elemWide = 1'b0, aSigned = 1'b0, bSigned = 1'b0;
  logic [7:0] laneMask = '0;
  logic [7:0] vl = '0, startIdx = '0;
  logic [511:0] accIn = '0;
  logic [15:0] aElem = '0;
  logic [127:0] bElems = '0;
  logic busy, done, err;
  logic [4:0] grpBase;
  logic [5:0] accIdx;
  logic [511:0] accOut;

  int testCnt = 0;
  int failCnt = 0;

  typedef struct {
    logic [511:0] acc;
    logic [4:0] base;
    logic [5:0] idx;
    string tag;
  } exp_t;
  exp_t expQ[$];

  logic [15:0] aVec [64];
  logic [15:0] bVec [8][64];

  always #2 clk = ~clk;

  batch_dot_acc i_batch_dot_acc (
    .clk(clk), .rst_n(rst_n), .start(start), .bReg(bReg), .elemWide(elemWide),
    .aSigned(aSigned), .bSigned(bSigned), .laneMask(laneMask), .vl(vl),
    .startIdx(startIdx), .accIn(accIn), .aElem(aElem), .bElems(bElems),
    .busy(busy), .done(done), .err(err), .grpBase(grpBase), .accIdx(accIdx),
    .accOut(accOut)
  );

  task automatic check64(input string req, input logic [63:0] act, input logic [63:0] expv);
    testCnt++;
    if (act !== expv) begin
      failCnt++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  function automatic longint extend(input logic [15:0] v, input bit wide, input bit sgn);
    if (wide) return sgn ? longint'($signed(v)) : longint'({48'b0, v});
    return sgn ? longint'($signed(v[7:0])) : longint'({56'b0, v[7:0]});
  endfunction

  // monitor: compares every completion against the scoreboard
  always @(negedge clk) begin
    if (rst_n && done) begin
      if (expQ.size() == 0) begin
        check64("R9 unexpected done", 64'd1, 64'd0);
      end else begin
        exp_t e;
        e = expQ.pop_front();
        for (int l = 0; l < 8; l++)
          check64(e.tag, accOut[l*64 +: 64], e.acc[l*64 +: 64]);
        check64("R1 grpBase", 64'(grpBase), 64'(e.base));
        check64("R1 accIdx", 64'(accIdx), 64'(e.idx));
      end
    end
  end

  task automatic fillData(input int seed);
    int s;
    s = seed;
    for (int k = 0; k < 64; k++) begin
      aVec[k] = 16'($urandom(s + k));
      for (int l = 0; l < 8; l++) bVec[l][k] = 16'($urandom(s * 7 + l * 131 + k));
    end
  endtask

  task automatic runOp(input bit wide, input bit aS, input bit bS, input logic [4:0] br,
                       input logic [7:0] mk, input int n, input int sIdx,
                       input bit hold, input bit expLegal, input string tag);
    logic [511:0] prior;
    exp_t e;
    @(negedge clk);
    prior = accOut;
    elemWide = wide; aSigned = aS; bSigned = bS; bReg = br;
    laneMask = mk; vl = 8'(n); startIdx = 8'(sIdx); start = 1'b1;
    if (expLegal) begin
      for (int l = 0; l < 8; l++) begin
        longint acc;
        acc = longint'(accIn[l*64 +: 64]);
        if (!wide) acc = acc & 64'h0000_0000_FFFF_FFFF;
        if (mk[l]) begin
          for (int k = 0; k < n; k++) begin
            acc = acc + extend(aVec[k], wide, aS) * extend(bVec[l][k], wide, bS);
            if (!wide) acc = acc & 64'h0000_0000_FFFF_FFFF;
          end
        end
        e.acc[l*64 +: 64] = acc;
      end
      e.base = {br[4:3], 3'b000};
      e.idx  = {br[2:0], 3'b000};
      e.tag  = tag;
      expQ.push_back(e);
    end
    @(posedge clk);
    @(negedge clk);
    if (!expLegal) begin
      check64({tag, " err"}, 64'(err), 64'd1);
      check64({tag, " no done"}, 64'(done), 64'd0);
      check64({tag, " accOut held"}, accOut[63:0] ^ accOut[511:448], prior[63:0] ^ prior[511:448]);
      testCnt++;
      if (accOut !== prior) begin
        failCnt++;
        $display("FAIL %s accOut changed actual=%h expected=%h", tag, accOut, prior);
      end
      start = 1'b0;
      return;
    end
    if (!hold) start = 1'b0;
    else begin
      bReg = br ^ 5'h0F; elemWide = ~wide; laneMask = ~mk;
    end
    for (int k = 0; k < n; k++) begin
      check64("R9 done early", 64'(done), 64'd0);
      aElem = aVec[k];
      for (int l = 0; l < 8; l++) bElems[l*16 +: 16] = bVec[l][k];
      @(posedge clk);
      @(negedge clk);
    end
    check64("R9 done on time", 64'(done), 64'd1);
    start = 1'b0;
    @(posedge clk);
    @(negedge clk);
    check64("R9 done single", 64'(done), 64'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failCnt++;
    testCnt++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("[TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check64("reset busy", 64'(busy), 64'd0);
    check64("reset done", 64'(done), 64'd0);
    check64("reset err", 64'(err), 64'd0);
    check64("reset accOut", accOut[63:0] | accOut[511:448], 64'd0);
    rst_n = 1'b1;

    // R2 R3 R5: 8-bit, both unsigned, upper element bits random
    fillData(11);
    for (int l = 0; l < 8; l++) accIn[l*64 +: 64] = {32'hDEAD_0000 + 32'(l), 32'h0000_1000 * 32'(l)};
    runOp(1'b0, 1'b0, 1'b0, 5'd8, 8'hFF, 5, 0, 1'b0, 1'b1, "R2 R3 R5 8b unsigned");

    // R5 R6 R1: 8-bit signed both, offset 24, masked lanes
    fillData(23);
    runOp(1'b0, 1'b1, 1'b1, 5'd11, 8'hA5, 7, 0, 1'b0, 1'b1, "R5 R6 8b signed masked");

    // R5: signed A, unsigned B, 8-bit
    fillData(37);
    runOp(1'b0, 1'b1, 1'b0, 5'd2, 8'h3C, 9, 0, 1'b0, 1'b1, "R5 8b A signed B unsigned");

    // R3: 32-bit wraparound
    for (int k = 0; k < 64; k++) begin
      aVec[k] = 16'h12FF;
      for (int l = 0; l < 8; l++) bVec[l][k] = 16'h34FF;
    end
    for (int l = 0; l < 8; l++) accIn[l*64 +: 64] = 64'h5555_5555_FFFF_FF00;
    runOp(1'b0, 1'b0, 1'b0, 5'd16, 8'hFF, 4, 0, 1'b0, 1'b1, "R3 8b wrap");

    // R4 R5: 16-bit, A signed, B unsigned, offset 8
    fillData(41);
    for (int l = 0; l < 8; l++) accIn[l*64 +: 64] = 64'h0123_4567_89AB_CDEF + 64'(l);
    runOp(1'b1, 1'b1, 1'b0, 5'd17, 8'hFF, 6, 0, 1'b0, 1'b1, "R4 R5 16b mixed");

    // R4 R5: 16-bit, A unsigned, B signed, 64-bit wraparound
    for (int k = 0; k < 64; k++) begin
      aVec[k] = 16'hFFFF;
      for (int l = 0; l < 8; l++) bVec[l][k] = (l % 2 == 0) ? 16'h8000 : 16'h7FFF;
    end
    for (int l = 0; l < 8; l++) accIn[l*64 +: 64] = (l % 2 == 0) ? 64'h8000_0000_0000_0100 : 64'h7FFF_FFFF_FFFF_FF00;
    runOp(1'b1, 1'b0, 1'b1, 5'd24, 8'hFF, 3, 0, 1'b0, 1'b1, "R4 16b wrap");

    // R10: zero-length operation in both modes
    fillData(53);
    runOp(1'b1, 1'b1, 1'b1, 5'd9, 8'hFF, 0, 0, 1'b0, 1'b1, "R10 vl zero 16b");
    runOp(1'b0, 1'b0, 1'b0, 5'd3, 8'h0F, 0, 0, 1'b0, 1'b1, "R10 vl zero 8b");

    // R7: nonzero resume index
    runOp(1'b0, 1'b0, 1'b0, 5'd0, 8'hFF, 4, 2, 1'b0, 1'b0, "R7 resume index");

    // R8: offset out of range in each mode
    runOp(1'b1, 1'b0, 1'b0, 5'd18, 8'hFF, 4, 0, 1'b0, 1'b0, "R8 16b offset");
    runOp(1'b0, 1'b0, 1'b0, 5'd4, 8'hFF, 4, 0, 1'b0, 1'b0, "R8 8b offset");

    // R11: start held high with altered configuration during a run
    fillData(67);
    runOp(1'b1, 1'b0, 1'b1, 5'd1, 8'h5A, 8, 0, 1'b1, 1'b1, "R11 start ignored when busy");

    // R2: longer stream
    fillData(71);
    runOp(1'b0, 1'b1, 1'b0, 5'd27, 8'hFF, 40, 0, 1'b0, 1'b1, "R2 long stream");

    repeat (3) @(negedge clk);
    check64("R9 all results delivered", 64'(expQ.size()), 64'd0);
    $display("[TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end
endmodule